// File: doc/BRIEF.md
# Streaming Multiprocessor Block Admission Tracker

This block decides whether a thread block may become resident on one streaming multiprocessor. A request carries the number of threads in the block, the registers each thread needs and the shared-memory bytes the block needs. The tracker keeps four occupancy pools: registers, thread lanes, warp slots and shared memory. It also keeps a table of resident-block slots. A block is admitted only when every pool can take the whole block. When a block is admitted, its charges are written into a free slot and added to the pools. When a block retires, naming its slot on the release port returns exactly those charges.

Threads are packed into warps of 32, rounding up. Thread lanes and registers are charged per whole warp, so the idle lanes of a partial last warp still count against both pools. As a result, the resident warp count is bounded by whichever pool runs dry first, not by any one fixed cap. The answer to each request arrives one cycle later together with the slot index the block was given. A release that arrives in the same cycle as a request is applied first, so the freed room and the freed slot are both available to that request.

Top module: `sm_admit_tracker`

## Requirements
- R1: After a synchronous active-low reset, resident_warps and resident_blocks are 0, and resp_valid and rel_error are low.
- R2: A block of T threads occupies ceil(T/32) warps. An accepted request raises resident_warps by exactly that amount.
- R3: Thread-lane usage is charged as warps×32 and register usage as warps×32×regs_per_thread. For example, eight 100-thread blocks fill the 1024-lane pool, so a ninth is rejected.
- R4: A request is accepted only if threads is nonzero, a slot is free, and after the charge registers ≤ 65536, lanes ≤ 1024, warps ≤ 64 and shared bytes ≤ 65536. Otherwise it is rejected.
- R5: req_valid in cycle n gives resp_valid high in cycle n+1, with resp_accept and resp_slot. resp_slot is the lowest-numbered free slot. Without a request, resp_valid is low.
- R6: A rejected request leaves every pool and resident_blocks unchanged.
- R7: Releasing an occupied slot returns exactly the amounts charged at its admission, and resident_blocks falls by one.
- R8: Releasing an unoccupied slot raises rel_error for one cycle, one cycle later, and changes no pool.
- R9: When a release and a request arrive in the same cycle, the release is applied before the admission check. The freed slot can be handed out again at once.
- R10: With 256-thread blocks, 64 registers per thread and 16384 shared bytes, four blocks are accepted and the fifth is rejected, leaving 32 resident warps.
- R11: resident_blocks equals the number of occupied slots and never exceeds the slot count, 16. When all slots are occupied, a request is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Admission request strobe |
| req_threads | input | 11 | Threads in the requested block |
| req_regs_per_thread | input | 8 | Registers each thread needs |
| req_smem_bytes | input | 17 | Shared-memory bytes the block needs |
| rel_valid | input | 1 | Release strobe |
| rel_slot | input | 4 | Slot of the retiring block |
| resp_valid | output | 1 | Response to last cycle's request |
| resp_accept | output | 1 | High when that request was admitted |
| resp_slot | output | 4 | Slot given to the admitted block |
| rel_error | output | 1 | Last cycle's release named an empty slot |
| resident_warps | output | 7 | Warps now resident |
| resident_blocks | output | 5 | Blocks now resident |

## Verification
Every result of this block is due exactly one clock edge after the cycle that caused it. This covers the response strobe, the accept bit and slot, the release error pulse, and the updated warp and block counts. The bench drives each cycle's request and release on the falling edge, then advances the same cycle's bench model. It compares every output shortly after the next rising edge, so each stimulus is paired with the edge that registers its answer. Same-cycle release-and-request cases apply the release in the model before the admission check, in the same order that the counts must show one edge later.

// File: rtl/sm_admit_pkg.sv
// Shared definitions for the block admission tracker.
// Assumes pools are indexed in the fixed order given by pool_e.
package sm_admit_pkg;
    typedef enum logic [1:0] {
        POOL_REG  = 2'd0,
        POOL_THR  = 2'd1,
        POOL_WARP = 2'd2,
        POOL_SMEM = 2'd3
    } pool_e;

    localparam int unsigned NUM_POOLS = 4;
    localparam int unsigned COST_W    = 32;

    // Largest of four capacities, used to size the pool counters.
    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/sm_cost_calc.sv
// Turns a block request into per-pool charges.
// Lanes and registers are charged for whole warps; a zero-thread
// request is flagged so the top can refuse it.
module sm_cost_calc
    import sm_admit_pkg::*;
#(
    parameter int unsigned WARP_SIZE = 32,
    parameter int unsigned THR_W     = 11,
    parameter int unsigned RPT_W     = 8,
    parameter int unsigned SMEM_W    = 17
) (
    input  logic [THR_W-1:0]  threads,
    input  logic [RPT_W-1:0]  regs_per_thread,
    input  logic [SMEM_W-1:0] smem_bytes,
    output logic [COST_W-1:0] need [NUM_POOLS],
    output logic              zero_req
);
    logic [COST_W-1:0] warps;
    logic [COST_W-1:0] lanes;

    // Round threads up to whole warps and derive every pool's charge.
    always_comb begin
        warps = (COST_W'(threads) + COST_W'(WARP_SIZE - 1)) / COST_W'(WARP_SIZE);
        lanes = warps * COST_W'(WARP_SIZE);
        need[POOL_REG]  = lanes * COST_W'(regs_per_thread);
        need[POOL_THR]  = lanes;
        need[POOL_WARP] = warps;
        need[POOL_SMEM] = COST_W'(smem_bytes);
        zero_req        = (threads == '0);
    end
endmodule

// File: rtl/sm_pool.sv
// One resource pool: a usage counter with a capacity check.
// The release amount is subtracted before the fit test, so a
// same-cycle release makes room for the request in that cycle.
module sm_pool
    import sm_admit_pkg::*;
#(
    parameter int unsigned CAP    = 1024,
    parameter int unsigned POOL_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_en,
    input  logic [POOL_W-1:0] rel_amt,
    input  logic [COST_W-1:0] need,
    input  logic              commit,
    output logic              fits,
    output logic [POOL_W-1:0] used
);
    logic [POOL_W-1:0] base;
    logic [COST_W:0]   total;

    // Usage after the release, and whether the request still fits.
    always_comb begin
        base  = rel_en ? (used - rel_amt) : used;
        total = (COST_W+1)'(base) + (COST_W+1)'(need);
        fits  = (total <= (COST_W+1)'(CAP));
    end

    // Register the new usage: release applied, admission charge added.
    always_ff @(posedge clk) begin
        if (!rst_n)      used <= '0;
        else if (commit) used <= base + need[POOL_W-1:0];
        else             used <= base;
    end
endmodule

// File: rtl/sm_slot_table.sv
// Table of resident-block slots.  Each slot remembers the charges
// taken at admission, so a release returns exactly those amounts.
// The free-slot search sees a slot freed in the same cycle.
module sm_slot_table
    import sm_admit_pkg::*;
#(
    parameter int unsigned SLOTS  = 16,
    parameter int unsigned POOL_W = 17,
    parameter int unsigned SLOT_W = 4,
    parameter int unsigned BLK_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_valid,
    input  logic [SLOT_W-1:0] rel_slot,
    input  logic              alloc,
    input  logic [POOL_W-1:0] charge  [NUM_POOLS],
    output logic              rel_hit,
    output logic [POOL_W-1:0] rel_amt [NUM_POOLS],
    output logic              free_found,
    output logic [SLOT_W-1:0] free_slot,
    output logic [BLK_W-1:0]  blocks
);
    logic [SLOTS-1:0]  occ;
    logic [SLOTS-1:0]  occ_after;
    logic [POOL_W-1:0] amt_q [SLOTS][NUM_POOLS];
    logic              rel_do;

    // Decode the release and read back the charges of that slot.
    always_comb begin
        rel_hit   = occ[rel_slot];
        rel_do    = rel_valid && rel_hit;
        occ_after = occ;
        if (rel_do) occ_after[rel_slot] = 1'b0;
        for (int p = 0; p < NUM_POOLS; p++) rel_amt[p] = amt_q[rel_slot][p];
    end

    // Find the lowest-numbered slot free after the release.
    always_comb begin
        free_found = 1'b0;
        free_slot  = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (!occ_after[s]) begin
                free_found = 1'b1;
                free_slot  = SLOT_W'(s);
            end
        end
    end

    // Update occupancy and the resident block count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ    <= '0;
            blocks <= '0;
        end else begin
            occ <= occ_after;
            if (alloc) occ[free_slot] <= 1'b1;
            case ({alloc, rel_do})
                2'b10:   blocks <= blocks + 1'b1;
                2'b01:   blocks <= blocks - 1'b1;
                default: blocks <= blocks;
            endcase
        end
    end

    // Record the charges of a newly admitted block.
    always_ff @(posedge clk) begin
        if (alloc) begin
            for (int p = 0; p < NUM_POOLS; p++) amt_q[free_slot][p] <= charge[p];
        end
    end
endmodule

// File: rtl/sm_admit_tracker.sv
// Admission tracker for one streaming multiprocessor.
// It admits a block only when all four pools and a slot have room.
// The answer comes one cycle after the request.  A release in the
// same cycle is applied first.
module sm_admit_tracker
    import sm_admit_pkg::*;
#(
    parameter int unsigned REG_TOTAL  = 65536,
    parameter int unsigned THR_TOTAL  = 1024,
    parameter int unsigned WARP_CAP   = 64,
    parameter int unsigned SMEM_TOTAL = 65536,
    parameter int unsigned WARP_SIZE  = 32,
    parameter int unsigned SLOTS      = 16,
    parameter int unsigned RPT_W      = 8,
    parameter int unsigned THR_W      = $clog2(THR_TOTAL + 1),
    parameter int unsigned SMEM_W     = $clog2(SMEM_TOTAL + 1),
    parameter int unsigned SLOT_W     = $clog2(SLOTS),
    parameter int unsigned WARP_W     = $clog2(WARP_CAP + 1),
    parameter int unsigned BLK_W      = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [THR_W-1:0]  req_threads,
    input  logic [RPT_W-1:0]  req_regs_per_thread,
    input  logic [SMEM_W-1:0] req_smem_bytes,
    input  logic              rel_valid,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic              resp_valid,
    output logic              resp_accept,
    output logic [SLOT_W-1:0] resp_slot,
    output logic              rel_error,
    output logic [WARP_W-1:0] resident_warps,
    output logic [BLK_W-1:0]  resident_blocks
);
    localparam int unsigned CAP_MAX = max4(REG_TOTAL, THR_TOTAL, WARP_CAP, SMEM_TOTAL);
    localparam int unsigned POOL_W  = $clog2(CAP_MAX + 1);
    localparam int unsigned CAPS [NUM_POOLS] = '{REG_TOTAL, THR_TOTAL, WARP_CAP, SMEM_TOTAL};

    logic [COST_W-1:0] need    [NUM_POOLS];
    logic [POOL_W-1:0] charge  [NUM_POOLS];
    logic [POOL_W-1:0] rel_amt [NUM_POOLS];
    logic [POOL_W-1:0] used    [NUM_POOLS];
    logic [NUM_POOLS-1:0] fits;
    logic              zero_req;
    logic              rel_hit;
    logic              free_found;
    logic [SLOT_W-1:0] free_slot;
    logic              commit;

    sm_cost_calc #(
        .WARP_SIZE (WARP_SIZE),
        .THR_W     (THR_W),
        .RPT_W     (RPT_W),
        .SMEM_W    (SMEM_W)
    ) u_cost (
        .threads         (req_threads),
        .regs_per_thread (req_regs_per_thread),
        .smem_bytes      (req_smem_bytes),
        .need            (need),
        .zero_req        (zero_req)
    );

    sm_slot_table #(
        .SLOTS  (SLOTS),
        .POOL_W (POOL_W),
        .SLOT_W (SLOT_W),
        .BLK_W  (BLK_W)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .rel_valid  (rel_valid),
        .rel_slot   (rel_slot),
        .alloc      (commit),
        .charge     (charge),
        .rel_hit    (rel_hit),
        .rel_amt    (rel_amt),
        .free_found (free_found),
        .free_slot  (free_slot),
        .blocks     (resident_blocks)
    );

    // One counter per resource pool.
    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        assign charge[p] = need[p][POOL_W-1:0];
        sm_pool #(
            .CAP    (CAPS[p]),
            .POOL_W (POOL_W)
        ) u_pool (
            .clk     (clk),
            .rst_n   (rst_n),
            .rel_en  (rel_valid && rel_hit),
            .rel_amt (rel_amt[p]),
            .need    (need[p]),
            .commit  (commit),
            .fits    (fits[p]),
            .used    (used[p])
        );
    end

    // Admit only when every pool fits, a slot is free and threads is nonzero.
    always_comb commit = req_valid && (&fits) && free_found && !zero_req;

    assign resident_warps = used[POOL_WARP][WARP_W-1:0];

    // Register the response and the release error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_accept <= 1'b0;
            resp_slot   <= '0;
            rel_error   <= 1'b0;
        end else begin
            resp_valid  <= req_valid;
            resp_accept <= commit;
            resp_slot   <= free_slot;
            rel_error   <= rel_valid && !rel_hit;
        end
    end
endmodule

// File: rtl/sm_admit_checker.sv
// Temporal checks on the admission tracker ports, bound to the top.
module sm_admit_checker #(
    parameter int unsigned WARP_CAP = 64,
    parameter int unsigned SLOTS    = 16,
    parameter int unsigned WARP_W   = 7,
    parameter int unsigned BLK_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rel_valid,
    input logic              resp_valid,
    input logic              resp_accept,
    input logic              rel_error,
    input logic [WARP_W-1:0] resident_warps,
    input logic [BLK_W-1:0]  resident_blocks
);
    p_resp_due_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    p_resp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resident_warps <= WARP_W'(WARP_CAP));
    p_blocks_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resident_blocks <= BLK_W'(SLOTS));
    p_reject_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rel_valid) |=>
            (!resp_accept -> ($stable(resident_warps) && $stable(resident_blocks))));
    p_accept_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rel_valid) |=>
            (resp_accept -> (resident_blocks == $past(resident_blocks) + 1'b1)));
    p_bad_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !req_valid) |=>
            (rel_error -> ($stable(resident_warps) && $stable(resident_blocks))));
endmodule

bind sm_admit_tracker sm_admit_checker #(
    .WARP_CAP (WARP_CAP),
    .SLOTS    (SLOTS),
    .WARP_W   (WARP_W),
    .BLK_W    (BLK_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .rel_valid       (rel_valid),
    .resp_valid      (resp_valid),
    .resp_accept     (resp_accept),
    .rel_error       (rel_error),
    .resident_warps  (resident_warps),
    .resident_blocks (resident_blocks)
);

// File: tb/sm_admit_tracker_test.sv
// Bench for the admission tracker: directed corners plus seeded random
// traffic, checked against a bench-side model of pools and slots.
module sm_admit_tracker_test;
    localparam int NSLOT = 16;
    localparam int CAPS [4] = '{65536, 1024, 64, 65536};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [10:0] req_threads = '0;
    logic [7:0]  req_regs_per_thread = '0;
    logic [16:0] req_smem_bytes = '0;
    logic        rel_valid = 1'b0;
    logic [3:0]  rel_slot = '0;
    logic        resp_valid;
    logic        resp_accept;
    logic [3:0]  resp_slot;
    logic        rel_error;
    logic [6:0]  resident_warps;
    logic [4:0]  resident_blocks;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    int m_used [4];
    bit m_occ  [NSLOT];
    int m_amt  [NSLOT][4];

    always #10 clk = ~clk;

    sm_admit_tracker uut (
        .clk                 (clk),
        .rst_n               (rst_n),
        .req_valid           (req_valid),
        .req_threads         (req_threads),
        .req_regs_per_thread (req_regs_per_thread),
        .req_smem_bytes      (req_smem_bytes),
        .rel_valid           (rel_valid),
        .rel_slot            (rel_slot),
        .resp_valid          (resp_valid),
        .resp_accept         (resp_accept),
        .resp_slot           (resp_slot),
        .rel_error           (rel_error),
        .resident_warps      (resident_warps),
        .resident_blocks     (resident_blocks)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int f_warps(input int th);
        return (th + 31) / 32;
    endfunction

    function automatic int f_need(input int p, input int th, input int rp, input int sm);
        case (p)
            0:       return f_warps(th) * 32 * rp;
            1:       return f_warps(th) * 32;
            2:       return f_warps(th);
            default: return sm;
        endcase
    endfunction

    function automatic int m_blocks();
        int c = 0;
        for (int s = 0; s < NSLOT; s++) c += m_occ[s];
        return c;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        rel_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 4; p++) m_used[p] = 0;
        for (int s = 0; s < NSLOT; s++) m_occ[s] = 1'b0;
    endtask

    // One cycle: drive at the falling edge, check just after the next rising edge.
    task automatic step(input bit rv, input int th, input int rp, input int sm,
                        input bit lv, input int ls, output bit acc, output int slot);
        bit exp_err;
        bit fit;
        int free;
        @(negedge clk);
        req_valid = rv;
        req_threads = 11'(th);
        req_regs_per_thread = 8'(rp);
        req_smem_bytes = 17'(sm);
        rel_valid = lv;
        rel_slot = 4'(ls);
        exp_err = lv && !m_occ[ls];
        if (lv && m_occ[ls]) begin
            for (int p = 0; p < 4; p++) m_used[p] -= m_amt[ls][p];
            m_occ[ls] = 1'b0;
        end
        free = -1;
        for (int s = NSLOT - 1; s >= 0; s--) if (!m_occ[s]) free = s;
        fit = rv && (th > 0) && (free >= 0);
        for (int p = 0; p < 4; p++)
            if (m_used[p] + f_need(p, th, rp, sm) > CAPS[p]) fit = 1'b0;
        acc = fit;
        slot = free;
        if (fit) begin
            m_occ[free] = 1'b1;
            for (int p = 0; p < 4; p++) begin
                m_amt[free][p] = f_need(p, th, rp, sm);
                m_used[p] += m_amt[free][p];
            end
        end
        @(posedge clk);
        #2;
        check("R5 resp_valid", resp_valid, rv);
        if (rv) check("R4 resp_accept", resp_accept, fit);
        if (fit) check("R5 resp_slot", resp_slot, free);
        check("R8 rel_error", rel_error, exp_err);
        check("R2 resident_warps", resident_warps, m_used[2]);
        check("R11 resident_blocks", resident_blocks, m_blocks());
        req_valid = 1'b0;
        rel_valid = 1'b0;
    endtask

    initial begin
        bit acc;
        int slot;
        void'($urandom(32'd2024));

        // R1: reset state
        do_reset();
        #2;
        check("R1 warps after reset", resident_warps, 0);
        check("R1 blocks after reset", resident_blocks, 0);
        check("R1 resp_valid after reset", resp_valid, 0);
        check("R1 rel_error after reset", rel_error, 0);

        // R10: occupancy example, four 8-warp blocks then rejection
        for (int i = 0; i < 5; i++) begin
            step(1, 256, 64, 16384, 0, 0, acc, slot);
            check("R10 accept pattern", resp_accept, (i < 4) ? 1 : 0);
        end
        check("R10 resident warps 32", resident_warps, 32);

        // R9: release slot 2 and request in the same cycle
        step(1, 256, 64, 16384, 1, 2, acc, slot);
        check("R9 same-cycle accept", resp_accept, 1);
        check("R9 freed slot reused", resp_slot, 2);

        // R8: release of an empty slot
        step(0, 0, 0, 0, 1, 9, acc, slot);
        check("R8 error pulse", rel_error, 1);
        step(0, 0, 0, 0, 0, 0, acc, slot);
        check("R8 pulse one cycle", rel_error, 0);

        // R7: exact return on release
        step(0, 0, 0, 0, 1, 0, acc, slot);
        check("R7 warps restored", resident_warps, 24);
        check("R7 blocks restored", resident_blocks, 3);

        // R6: rejection changes nothing (shared memory too big for free room)
        step(1, 32, 1, 65536, 0, 0, acc, slot);
        check("R6 reject", resp_accept, 0);
        check("R6 warps unchanged", resident_warps, 24);

        // R3: partial warps charge whole lanes
        do_reset();
        for (int i = 0; i < 9; i++) step(1, 100, 1, 0, 0, 0, acc, slot);
        check("R3 ninth 100-thread block rejected", resp_accept, 0);
        check("R3 warps 32", resident_warps, 32);
        do_reset();
        for (int i = 0; i < 5; i++) step(1, 33, 255, 0, 0, 0, acc, slot);
        check("R3 register whole-warp reject", resp_accept, 0);
        check("R3 four register blocks", resident_blocks, 4);

        // R4: zero threads refused
        step(1, 0, 1, 0, 0, 0, acc, slot);
        check("R4 zero-thread reject", resp_accept, 0);

        // R11: slot table full
        do_reset();
        for (int i = 0; i < 17; i++) step(1, 1, 1, 0, 0, 0, acc, slot);
        check("R11 slots full reject", resp_accept, 0);
        check("R11 blocks at cap", resident_blocks, 16);

        // Random traffic mixing requests and releases
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int th;
            th = ($urandom % 8 == 0) ? int'($urandom % 1025) : int'($urandom % 300);
            step(($urandom % 4) != 0, th, 1 + int'($urandom % 64), int'($urandom % 20000),
                 ($urandom % 3) == 0, int'($urandom % NSLOT), acc, slot);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule